// File: doc/BRIEF.md
# DDR SDRAM Command Protocol Checker

This block passively watches the command bus of a four-bank DDR SDRAM on every rising clock edge. It decodes each command from clock enable, chip select, the three strobes, the bank address and the address bus. It tracks which banks hold an open row and counts clock cycles since the events that start each timing rule. It drives no bus signal. It is placed next to a memory controller, in simulation or in silicon, to catch protocol mistakes.

On the first violation it records an error code, the command class that broke the rule and the bank involved. That record holds until reset, so the first failure is never hidden by the ones that follow it. Every timing limit is given as a time in picoseconds and is converted to clock cycles from the clock period parameter. Minimum spacings round up. The maximum open time rounds down.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: After reset, err_flag, err_code, err_cmd and err_bank are all 0, and all four banks are tracked as idle.
- R2: The first violation sets err_flag and latches err_code, err_cmd and err_bank. Later violations do not change them until reset. err_cmd encodes 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh (auto or self), 6 mode register set (either), 7 burst stop. When several rules fail in one cycle, the order is: tMRD, then tRFC, then the command's own checks, then the open-too-long check.
- R3: A read or write to an idle bank gives code 1. An activate to a bank that already has an open row gives code 2.
- R4: A mode register set, auto refresh or self refresh entry while any bank is open gives code 3, with err_bank set to the lowest open bank.
- R5: Any command other than a no-op issued fewer than 2 cycles after a mode register set gives code 4. A command exactly 2 cycles later is legal.
- R6: Any command other than a no-op issued fewer than 10 cycles after an auto refresh or self refresh entry gives code 5.
- R7: A read or write fewer than 3 cycles after the activate of its bank gives code 6. The checks for that command run in this order: code 12, then code 1, then code 6.
- R8: An activate fewer than 3 cycles after a precharge of its bank gives code 7. A read or write with address bit 10 high starts that bank's precharge in the cycle the command is issued. The checks for an activate run in this order: code 2, then 7, then 10, then 9.
- R9: A precharge of an open bank fewer than 6 cycles after its activate gives code 8. With address bit 10 high, the bank address is ignored and every open bank is checked, with the lowest offending bank reported. Every bank is then idle.
- R10: An activate fewer than 2 cycles after an activate of another bank gives code 9. An activate fewer than 9 cycles after the previous activate of the same bank gives code 10.
- R11: A bank still open 16001 or more cycles after its activate gives code 11, with err_cmd 0 and the lowest such bank reported. A bank precharged at exactly 16000 cycles is legal.
- R12: A read or write to a bank fewer than 3 cycles after a write with auto precharge to that bank gives code 12.
- R13: The bus is not decoded in a cycle that follows one with clock enable low. When clock enable falls, only the refresh encoding is decoded, as self refresh entry. Any other encoding on that edge is power-down entry and counts as a no-op, as does chip select high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable as seen by the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address bus; bit 10 selects auto precharge or precharge-all |
| err_flag | output | 1 | A violation has been recorded |
| err_code | output | 4 | Code of the recorded violation |
| err_cmd | output | 3 | Command class of the recorded violation |
| err_bank | output | 2 | Bank of the recorded violation |

## Verification
Each rule is driven once at its exact cycle limit and once a single cycle inside it. This separates an off-by-one counter from a correct one, and rounding up from rounding down. Sequences that break two rules in the same cycle show whether the priority order holds. A second error after the first shows that the record does not move. Power-down, self refresh, deselect cycles carrying strobe patterns, and precharge-all issued with a misleading bank address tell apart commands that must be ignored from commands that must be decoded. A reference model that counts absolute cycles is compared with the outputs on every clock.

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor #(
  parameter int CLK_PS     = 7500,
  parameter int RCD_PS     = 20000,
  parameter int RP_PS      = 20000,
  parameter int RAS_PS     = 45000,
  parameter int RRD_PS     = 15000,
  parameter int RC_PS      = 65000,
  parameter int RFC_PS     = 75000,
  parameter int RAS_MAX_PS = 120000000,
  parameter int MRD_CYC    = 2,
  parameter int BURST_LEN  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cke,
  input  logic        cs_n,
  input  logic        ras_n,
  input  logic        cas_n,
  input  logic        we_n,
  input  logic [1:0]  ba,
  input  logic [12:0] addr,
  output logic        err_flag,
  output logic [3:0]  err_code,
  output logic [2:0]  err_cmd,
  output logic [1:0]  err_bank
);
  localparam int T_RCD     = (RCD_PS + CLK_PS - 1) / CLK_PS;
  localparam int T_RP      = (RP_PS  + CLK_PS - 1) / CLK_PS;
  localparam int T_RAS     = (RAS_PS + CLK_PS - 1) / CLK_PS;
  localparam int T_RRD     = (RRD_PS + CLK_PS - 1) / CLK_PS;
  localparam int T_RC      = (RC_PS  + CLK_PS - 1) / CLK_PS;
  localparam int T_RFC     = (RFC_PS + CLK_PS - 1) / CLK_PS;
  localparam int T_RAS_MAX = RAS_MAX_PS / CLK_PS;
  localparam int T_WAP     = BURST_LEN / 2 + 1;
  localparam int CW        = $clog2(T_RAS_MAX + T_RFC + T_RC + 2);

  localparam logic [CW-1:0] SAT      = '1;
  localparam logic [CW-1:0] ONE      = CW'(1);
  localparam logic [CW-1:0] C_RCD    = CW'(T_RCD);
  localparam logic [CW-1:0] C_RP     = CW'(T_RP);
  localparam logic [CW-1:0] C_RAS    = CW'(T_RAS);
  localparam logic [CW-1:0] C_RRD    = CW'(T_RRD);
  localparam logic [CW-1:0] C_RC     = CW'(T_RC);
  localparam logic [CW-1:0] C_RFC    = CW'(T_RFC);
  localparam logic [CW-1:0] C_RASMAX = CW'(T_RAS_MAX);
  localparam logic [CW-1:0] C_MRD    = CW'(MRD_CYC);
  localparam logic [CW-1:0] C_WAP    = CW'(T_WAP);

  localparam logic [2:0] K_NOP = 3'd0, K_ACT = 3'd1, K_RD  = 3'd2, K_WR  = 3'd3,
                         K_PRE = 3'd4, K_REF = 3'd5, K_MRS = 3'd6, K_BST = 3'd7;

  logic          cke_q;
  logic [3:0]    open_q;
  logic [CW-1:0] act_c [4];
  logic [CW-1:0] pre_c [4];
  logic [CW-1:0] wap_c [4];
  logic [CW-1:0] ref_c, mrs_c;

  logic [2:0] cmd;
  logic [3:0] code_n, close_v;
  logic [2:0] cmd_n;
  logic [1:0] bank_n, open_lo, ras_lo, max_lo;
  logic       ras_any, max_any, rrd_hit;
  logic       unused_addr;

  assign unused_addr = ^{addr[12:11], addr[9:0]};

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return (v == SAT) ? v : v + ONE;
  endfunction

  always_comb begin
    cmd = K_NOP;
    if (cke_q && !cs_n && (cke || {ras_n, cas_n, we_n} == 3'b001))
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = K_MRS;
        3'b001:  cmd = K_REF;
        3'b011:  cmd = K_ACT;
        3'b101:  cmd = K_RD;
        3'b100:  cmd = K_WR;
        3'b110:  cmd = K_BST;
        3'b010:  cmd = K_PRE;
        default: cmd = K_NOP;
      endcase
  end

  always_comb begin
    open_lo = 2'd0; ras_lo = 2'd0; max_lo = 2'd0;
    ras_any = 1'b0; max_any = 1'b0; rrd_hit = 1'b0; close_v = 4'b0;
    for (int i = 3; i >= 0; i--) begin
      if (open_q[i]) open_lo = 2'(i);
      if (open_q[i] && act_c[i] < C_RAS) begin ras_any = 1'b1; ras_lo = 2'(i); end
      if (open_q[i] && act_c[i] > C_RASMAX) begin max_any = 1'b1; max_lo = 2'(i); end
      if (2'(i) != ba && act_c[i] < C_RRD) rrd_hit = 1'b1;
      if ((cmd == K_PRE && (addr[10] || ba == 2'(i))) ||
          ((cmd == K_RD || cmd == K_WR) && addr[10] && ba == 2'(i)))
        close_v[i] = 1'b1;
    end
  end

  always_comb begin
    code_n = 4'd0;
    bank_n = ba;
    cmd_n  = cmd;
    if (cmd != K_NOP && mrs_c < C_MRD)      code_n = 4'd4;
    else if (cmd != K_NOP && ref_c < C_RFC) code_n = 4'd5;
    else
      case (cmd)
        K_ACT: begin
          if (open_q[ba])             code_n = 4'd2;
          else if (pre_c[ba] < C_RP)  code_n = 4'd7;
          else if (act_c[ba] < C_RC)  code_n = 4'd10;
          else if (rrd_hit)           code_n = 4'd9;
        end
        K_RD, K_WR: begin
          if (wap_c[ba] < C_WAP)      code_n = 4'd12;
          else if (!open_q[ba])       code_n = 4'd1;
          else if (act_c[ba] < C_RCD) code_n = 4'd6;
        end
        K_PRE: begin
          if (addr[10]) begin
            if (ras_any) begin code_n = 4'd8; bank_n = ras_lo; end
          end else if (open_q[ba] && act_c[ba] < C_RAS) code_n = 4'd8;
        end
        K_REF, K_MRS: if (|open_q) begin code_n = 4'd3; bank_n = open_lo; end
        default: ;
      endcase
    if (code_n == 4'd0 && max_any) begin
      code_n = 4'd11; bank_n = max_lo; cmd_n = K_NOP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q <= 1'b1;
      open_q <= 4'b0;
      ref_c <= SAT;
      mrs_c <= SAT;
      for (int i = 0; i < 4; i++) begin
        act_c[i] <= SAT; pre_c[i] <= SAT; wap_c[i] <= SAT;
      end
      err_flag <= 1'b0; err_code <= 4'd0; err_cmd <= 3'd0; err_bank <= 2'd0;
    end else begin
      cke_q <= cke;
      ref_c <= (cmd == K_REF) ? ONE : bump(ref_c);
      mrs_c <= (cmd == K_MRS) ? ONE : bump(mrs_c);
      for (int i = 0; i < 4; i++) begin
        act_c[i]  <= (cmd == K_ACT && ba == 2'(i)) ? ONE : bump(act_c[i]);
        pre_c[i]  <= close_v[i] ? ONE : bump(pre_c[i]);
        wap_c[i]  <= (cmd == K_WR && addr[10] && ba == 2'(i)) ? ONE : bump(wap_c[i]);
        open_q[i] <= (cmd == K_ACT && ba == 2'(i)) ? 1'b1 : (close_v[i] ? 1'b0 : open_q[i]);
      end
      if (!err_flag && code_n != 4'd0) begin
        err_flag <= 1'b1; err_code <= code_n; err_cmd <= cmd_n; err_bank <= bank_n;
      end
    end
  end
endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       ap,
  input logic       cke_q,
  input logic [3:0] open_q,
  input logic       err_flag,
  input logic [3:0] err_code,
  input logic [2:0] err_cmd,
  input logic [1:0] err_bank
);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag && $stable(err_code) && $stable(err_cmd) && $stable(err_bank));

  assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> (err_code != 4'd0 && err_code <= 4'd12));

  assert_idle_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && cke_q && cke && !cs_n && ras_n && !cas_n && open_q == 4'b0) |=> err_flag);

  assert_busy_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && cke_q && cke && !cs_n && !ras_n && !cas_n && !we_n && open_q != 4'b0) |=> err_flag);

  assert_prea_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_q && cke && !cs_n && !ras_n && cas_n && !we_n && ap) |=> open_q == 4'b0);

  assert_cke_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> $stable(open_q));
endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ap(addr[10]), .cke_q(cke_q), .open_q(open_q), .err_flag(err_flag),
  .err_code(err_code), .err_cmd(err_cmd), .err_bank(err_bank)
);

// File: tb/ddr_cmd_monitor_bench.sv
module ddr_cmd_monitor_bench;
  localparam int RCD = 3, RP = 3, RAS = 6, RRD = 2, RC = 9, RFC = 10, MRD = 2, WAP = 3;
  localparam int RASMAX = 16000;
  localparam int FAR = -100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = 2'd0;
  logic [12:0] addr = 13'd0;
  logic        err_flag;
  logic [3:0]  err_code;
  logic [2:0]  err_cmd;
  logic [1:0]  err_bank;

  int vectors = 0, fails = 0;
  string cur_req = "R1";

  ddr_cmd_monitor u_ddr_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .err_flag(err_flag), .err_code(err_code),
    .err_cmd(err_cmd), .err_bank(err_bank)
  );

  always #10 clk = ~clk;

  int cyc = 0, lr = FAR, lm = FAR;
  int la [4] = '{FAR, FAR, FAR, FAR};
  int lp [4] = '{FAR, FAR, FAR, FAR};
  int lw [4] = '{FAR, FAR, FAR, FAR};
  bit mo [4] = '{0, 0, 0, 0};
  bit mcke = 1'b1;
  bit ef = 1'b0;
  int ec = 0, ecmd = 0, eb = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; lr = FAR; lm = FAR; mcke = 1'b1;
      for (int j = 0; j < 4; j++) begin la[j] = FAR; lp[j] = FAR; lw[j] = FAR; mo[j] = 1'b0; end
      ef = 1'b0; ec = 0; ecmd = 0; eb = 0;
    end else begin
      int c, b, e, bk, m;
      cyc++;
      c = 0;
      if (mcke && !cs_n && (cke || {ras_n, cas_n, we_n} == 3'b001))
        case ({ras_n, cas_n, we_n})
          3'b000: c = 6; 3'b001: c = 5; 3'b011: c = 1; 3'b101: c = 2;
          3'b100: c = 3; 3'b110: c = 7; 3'b010: c = 4; default: c = 0;
        endcase
      b = int'(ba); e = 0; bk = b; m = c;
      if (c != 0 && cyc - lm < MRD) e = 4;
      else if (c != 0 && cyc - lr < RFC) e = 5;
      else if (c == 1) begin
        if (mo[b]) e = 2;
        else if (cyc - lp[b] < RP) e = 7;
        else if (cyc - la[b] < RC) e = 10;
        else for (int j = 0; j < 4; j++) if (j != b && cyc - la[j] < RRD) e = 9;
      end else if (c == 2 || c == 3) begin
        if (cyc - lw[b] < WAP) e = 12;
        else if (!mo[b]) e = 1;
        else if (cyc - la[b] < RCD) e = 6;
      end else if (c == 4) begin
        if (addr[10]) begin
          for (int j = 3; j >= 0; j--) if (mo[j] && cyc - la[j] < RAS) begin e = 8; bk = j; end
        end else if (mo[b] && cyc - la[b] < RAS) e = 8;
      end else if (c == 5 || c == 6) begin
        for (int j = 3; j >= 0; j--) if (mo[j]) begin e = 3; bk = j; end
      end
      if (e == 0)
        for (int j = 3; j >= 0; j--) if (mo[j] && cyc - la[j] > RASMAX) begin e = 11; bk = j; m = 0; end
      if (!ef && e != 0) begin ef = 1'b1; ec = e; ecmd = m; eb = bk; end
      if (c == 1) begin mo[b] = 1'b1; la[b] = cyc; end
      if ((c == 2 || c == 3) && addr[10]) begin
        mo[b] = 1'b0; lp[b] = cyc;
        if (c == 3) lw[b] = cyc;
      end
      if (c == 4)
        for (int j = 0; j < 4; j++) if (addr[10] || j == b) begin mo[j] = 1'b0; lp[j] = cyc; end
      if (c == 5) lr = cyc;
      if (c == 6) lm = cyc;
      mcke = cke;
    end
  end

  always @(negedge clk) begin
    #2;
    vectors++;
    if (err_flag !== ef || err_code !== 4'(ec) || err_cmd !== 3'(ecmd) || err_bank !== 2'(eb)) begin
      fails++;
      $display("FAIL %s model: actual flag=%0b code=%0d cmd=%0d bank=%0d expected flag=%0b code=%0d cmd=%0d bank=%0d",
               cur_req, err_flag, err_code, err_cmd, err_bank, ef, ec, ecmd, eb);
    end
  end

  task automatic put(input int c, input int b, input bit a10, input bit ck);
    @(negedge clk);
    cke = ck; cs_n = 1'b0; ba = 2'(b);
    addr = 13'h14A5; addr[10] = a10;
    case (c)
      1: {ras_n, cas_n, we_n} = 3'b011;
      2: {ras_n, cas_n, we_n} = 3'b101;
      3: {ras_n, cas_n, we_n} = 3'b100;
      4: {ras_n, cas_n, we_n} = 3'b010;
      5: {ras_n, cas_n, we_n} = 3'b001;
      6: {ras_n, cas_n, we_n} = 3'b000;
      7: {ras_n, cas_n, we_n} = 3'b110;
      default: {ras_n, cas_n, we_n} = 3'b111;
    endcase
  endtask

  task automatic nops(input int n);
    repeat (n) put(0, 0, 1'b0, 1'b1);
  endtask

  task automatic deselect();
    @(negedge clk);
    cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b000;
  endtask

  task automatic expect_err(input bit f, input int code, input int cm, input int bank, input string req);
    @(negedge clk);
    cke = 1'b1; cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b111;
    #2;
    vectors++;
    if (err_flag !== f || err_code !== 4'(code) || err_cmd !== 3'(cm) || err_bank !== 2'(bank)) begin
      fails++;
      $display("FAIL %s: actual flag=%0b code=%0d cmd=%0d bank=%0d expected flag=%0b code=%0d cmd=%0d bank=%0d",
               req, err_flag, err_code, err_cmd, err_bank, f, code, cm, bank);
    end
  endtask

  task automatic do_reset(input string req);
    @(negedge clk);
    cur_req = req;
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b111;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    do_reset("R1");
    expect_err(0, 0, 0, 0, "R1");

    do_reset("R7");
    put(1, 0, 0, 1); nops(1); put(1, 1, 0, 1); put(2, 0, 0, 1); nops(2);
    put(4, 0, 0, 1); put(3, 1, 0, 1); put(7, 0, 0, 1); put(1, 0, 0, 1);
    expect_err(0, 0, 0, 0, "R7 R8 R9 R10 legal limits");

    do_reset("R7");
    put(1, 2, 0, 1); nops(1); put(2, 2, 0, 1);
    expect_err(1, 6, 2, 2, "R7");

    do_reset("R3");
    put(2, 1, 0, 1);
    expect_err(1, 1, 2, 1, "R3 idle");

    do_reset("R3");
    put(1, 3, 0, 1); nops(10); put(1, 3, 0, 1);
    expect_err(1, 2, 1, 3, "R3 open");

    do_reset("R4");
    put(1, 1, 0, 1); nops(10); put(6, 0, 0, 1);
    expect_err(1, 3, 6, 1, "R4");

    do_reset("R5");
    put(6, 0, 0, 1); put(1, 0, 0, 1);
    expect_err(1, 4, 1, 0, "R5");

    do_reset("R5");
    put(6, 1, 0, 1); nops(1); put(1, 0, 0, 1);
    expect_err(0, 0, 0, 0, "R5 legal");

    do_reset("R6");
    put(5, 0, 0, 1); nops(8); put(1, 3, 0, 1);
    expect_err(1, 5, 1, 3, "R6");

    do_reset("R6");
    put(5, 0, 0, 1); nops(9); put(1, 3, 0, 1);
    expect_err(0, 0, 0, 0, "R6 legal");

    do_reset("R8");
    put(1, 0, 0, 1); nops(6); put(4, 0, 0, 1); nops(1); put(1, 0, 0, 1);
    expect_err(1, 7, 1, 0, "R8");

    do_reset("R9");
    put(1, 2, 0, 1); nops(3); put(4, 1, 1, 1);
    expect_err(1, 8, 4, 2, "R9 precharge all");

    do_reset("R10");
    put(1, 0, 0, 1); put(1, 1, 0, 1);
    expect_err(1, 9, 1, 1, "R10 other bank");
    put(2, 3, 0, 1); put(6, 0, 0, 1);
    expect_err(1, 9, 1, 1, "R2 sticky");

    do_reset("R10");
    put(1, 0, 0, 1); nops(2); put(2, 0, 1, 1); nops(2); put(1, 0, 0, 1);
    expect_err(1, 10, 1, 0, "R10 same bank");

    do_reset("R2");
    put(5, 0, 0, 1); nops(3); put(6, 0, 0, 1); put(2, 2, 0, 1);
    expect_err(1, 5, 6, 0, "R2 priority");

    do_reset("R12");
    put(1, 1, 0, 1); nops(3); put(3, 1, 1, 1); put(3, 1, 0, 1);
    expect_err(1, 12, 3, 1, "R12");

    do_reset("R13");
    put(1, 0, 0, 1); nops(3); put(0, 0, 0, 0); put(2, 3, 0, 0); put(0, 0, 0, 0);
    put(2, 3, 0, 1); deselect(); deselect();
    expect_err(0, 0, 0, 0, "R13 power-down and deselect");
    put(4, 2, 1, 1); nops(3); put(5, 0, 0, 0); put(2, 2, 0, 0); put(0, 0, 0, 1); nops(10);
    expect_err(0, 0, 0, 0, "R13 self refresh");

    do_reset("R13");
    put(1, 2, 0, 1); nops(10); put(5, 0, 0, 0);
    expect_err(1, 3, 5, 2, "R13 R4 self refresh open bank");

    do_reset("R11");
    put(1, 0, 0, 1); nops(RASMAX);
    expect_err(0, 0, 0, 0, "R11 limit");
    expect_err(1, 11, 0, 0, "R11 exceeded");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule